// File: doc/BRIEF.md
# DRAM Self-Refresh Command Sequencer

This block sits between a power-management controller and a DRAM command issuer. Software loads eight 16-bit command words and an enable bit through a small register write/read port. When the power manager raises its request line, the block replays the first four words, one per issue slot, onto a compact command output. It then raises an acknowledge to report that the memory has entered self-refresh. When the request line drops while the acknowledge is high, the block replays the other four words and then lowers the acknowledge.

Each stored word has two parts. The top nibble is the number of idle cycles to insert after that command. The low twelve bits are the command payload, such as a refresh, activate or precharge, or a mode-register write. The payload leaves the block with a one-cycle valid strobe. When a sequence starts, the block takes a private copy of the four words it needs, so software activity during a replay cannot disturb it.

Top module: `sr_cmd_seq`

## Requirements
- R1: After reset, every command register and the enable bit read as zero, the acknowledge is low and no command is issued.
- R2: The enable bit is bit 0 at register offset 0x10, and command word n (0..7) is at offset 0x18 + 4n. Writes take effect on the clock edge and reads return stored values combinationally. Any other offset reads as zero.
- R3: A request rising edge while acknowledge is low and the enable is set issues words 0, 1, 2, 3 in that order. Word 0 appears in the cycle that follows the first clock edge at which the request is seen high.
- R4: A command word carries the payload in bits [11:0] and the wait w in bits [15:12]. The payload is presented on the command output with the valid strobe high for exactly one cycle. The next command, or the end of the sequence, follows w idle cycles later, and valid stays low during those cycles.
- R5: Acknowledge rises on the clock edge that ends the wait of word 3, or the edge after word 3's issue cycle if its wait is zero.
- R6: A request rising edge while the enable is clear issues no command and leaves acknowledge low. The matching falling edge is also ignored.
- R7: A request held at a constant level issues nothing and leaves acknowledge unchanged.
- R8: A request falling edge while acknowledge is high issues words 4, 5, 6, 7 in order, with the same timing as entry, and lowers acknowledge when the last wait ends. This happens whatever the enable bit holds.
- R9: Register writes, including writes to the enable bit, made while a sequence runs do not change the words that sequence issues.
- R10: Request edges that arrive while a sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pm_req | input | 1 | Self-refresh request from the power manager |
| pm_ack | output | 1 | Self-refresh acknowledge to the power manager |
| cmd_valid | output | 1 | One-cycle strobe marking a command |
| cmd_word | output | 12 | Command payload, zero when no strobe |

## Verification
A request edge driven before a clock edge shows up as word 0 in the cycle after that edge. Each later word is due w+1 cycles after the one before it, and the acknowledge changes one edge after the final issue or wait cycle. The bench keeps a mirror of the registers and copies the four words at the moment it drives the edge. It then walks the sequence one cycle at a time, sampling on falling clock edges. In every cycle it checks that the strobe, the payload and the unchanged acknowledge match the wait counts taken from its copy. Random writes and request glitches are placed only in cycles that still belong to the running sequence, so the expected trace cannot move.

// File: rtl/sr_cmd_seq.sv
module sr_cmd_seq #(
  parameter int CMD_W     = 16,
  parameter int WAIT_W    = 4,
  parameter int ADDR_W    = 8,
  parameter int N_STEP    = 4,
  parameter int CTRL_ADDR = 'h10,
  parameter int CMD_BASE  = 'h18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [CMD_W-1:0]        reg_wdata,
  output logic [CMD_W-1:0]        reg_rdata,
  input  logic                    pm_req,
  output logic                    pm_ack,
  output logic                    cmd_valid,
  output logic [CMD_W-WAIT_W-1:0] cmd_word
);
  localparam int OUT_W = CMD_W - WAIT_W;
  localparam int N_REG = 2 * N_STEP;
  localparam int IDX_W = (N_STEP > 1) ? $clog2(N_STEP) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_HOLD} st_t;

  logic [CMD_W-1:0]  cmd_q [N_REG];
  logic [CMD_W-1:0]  snap  [N_STEP];
  logic              en_q, req_q, dir_exit;
  st_t               state;
  logic [IDX_W-1:0]  idx;
  logic [WAIT_W-1:0] cnt;

  wire rise = pm_req & ~req_q;
  wire fall = ~pm_req & req_q;
  wire [CMD_W-1:0]  cur      = snap[idx];
  wire [WAIT_W-1:0] cur_wait = cur[CMD_W-1 -: WAIT_W];
  wire last      = (idx == IDX_W'(N_STEP - 1));
  wire step_done = (state == S_ISSUE && cur_wait == '0) || (state == S_HOLD && cnt == WAIT_W'(1));
  wire go_entry  = (state == S_IDLE) && rise && en_q && !pm_ack;
  wire go_exit   = (state == S_IDLE) && fall && pm_ack;

  assign cmd_valid = (state == S_ISSUE);
  assign cmd_word  = cmd_valid ? cur[OUT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      for (int i = 0; i < N_REG; i++) cmd_q[i] <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(CTRL_ADDR)) en_q <= reg_wdata[0];
      for (int i = 0; i < N_REG; i++)
        if (reg_addr == ADDR_W'(CMD_BASE + 4 * i)) cmd_q[i] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata[0] = en_q;
    for (int i = 0; i < N_REG; i++)
      if (reg_addr == ADDR_W'(CMD_BASE + 4 * i)) reg_rdata = cmd_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      pm_ack   <= 1'b0;
      state    <= S_IDLE;
      dir_exit <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      for (int k = 0; k < N_STEP; k++) snap[k] <= '0;
    end else begin
      req_q <= pm_req;
      case (state)
        S_IDLE: if (go_entry || go_exit) begin
          state    <= S_ISSUE;
          dir_exit <= go_exit;
          idx      <= '0;
          for (int k = 0; k < N_STEP; k++) snap[k] <= cmd_q[go_exit ? k + N_STEP : k];
        end
        S_ISSUE: if (cur_wait != '0) begin
          cnt   <= cur_wait;
          state <= S_HOLD;
        end
        S_HOLD: cnt <= cnt - WAIT_W'(1);
        default: state <= S_IDLE;
      endcase
      if (step_done) begin
        if (last) begin
          pm_ack <= !dir_exit;
          state  <= S_IDLE;
        end else begin
          idx   <= idx + IDX_W'(1);
          state <= S_ISSUE;
        end
      end
    end
  end

  // R3
  first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_entry |=> cmd_valid && cmd_word == $past(cmd_q[0][OUT_W-1:0]));
  // R4
  wait_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cur_wait != '0) |=> !cmd_valid);
  // R5
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pm_ack) |-> $past(state != S_IDLE) && !cmd_valid);
  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pm_ack) |-> $past(dir_exit));
  // R6
  dis_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && rise && !en_q && !pm_ack) |=> !cmd_valid && !pm_ack);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !rise && !fall) |=> !cmd_valid && $stable(pm_ack));
  // R10
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !step_done) |=> state != S_IDLE);
endmodule

// File: tb/sim_sr_cmd_seq.sv
module sim_sr_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, pm_req = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic pm_ack, cmd_valid;
  logic [11:0] cmd_word;

  int total = 0, bad = 0;
  logic [15:0] m [8];
  logic en_m;

  sr_cmd_seq u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
                 .pm_req, .pm_ack, .cmd_valid, .cmd_word);

  always #10 clk = ~clk;

  function automatic logic [7:0] cmd_addr(input int n);
    return 8'(8'h18 + 4 * n);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 8'h10) en_m = d[0];
    for (int i = 0; i < 8; i++) if (a == cmd_addr(i)) m[i] = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; #1;
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic hold(input int n, input logic exp_ack, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!cmd_valid && pm_ack == exp_ack, tag, {cmd_valid, pm_ack}, {1'b0, exp_ack});
    end
  endtask

  task automatic mid(input int c, input int tot, input logic level, input bit noisy);
    reg_we = 1'b0;
    pm_req = level;
    if (!noisy) return;
    if ($urandom % 2 == 0) begin
      int sel = $urandom % 9;
      logic [15:0] d = 16'($urandom);
      reg_we = 1'b1;
      reg_addr = (sel == 8) ? 8'h10 : cmd_addr(sel);
      reg_wdata = d;
      if (sel == 8) en_m = d[0]; else m[sel] = d;
    end
    if (c < tot && $urandom % 4 == 0) pm_req = ~level;
  endtask

  task automatic run_seq(input bit is_exit, input bit noisy);
    logic [15:0] s [4];
    int tot = 0, c = 0;
    logic level = !is_exit;
    for (int k = 0; k < 4; k++) begin
      s[k] = m[k + (is_exit ? 4 : 0)];
      tot += 1 + int'(s[k][15:12]);
    end
    @(negedge clk);
    pm_req = level;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk); c++;
      chk(cmd_valid && cmd_word == s[k][11:0],
          is_exit ? "R8 exit word order (R4 R9)" : "R3 entry word order (R4 R9)",
          {cmd_valid, cmd_word}, {1'b1, s[k][11:0]});
      chk(pm_ack == is_exit, "R10 ack steady mid-sequence", pm_ack, is_exit);
      mid(c, tot, level, noisy);
      for (int j = 0; j < int'(s[k][15:12]); j++) begin
        @(posedge clk); @(negedge clk); c++;
        chk(!cmd_valid && pm_ack == is_exit, "R4 wait gap", {cmd_valid, pm_ack}, {1'b0, is_exit});
        mid(c, tot, level, noisy);
      end
    end
    @(posedge clk); @(negedge clk);
    chk(pm_ack == level && !cmd_valid, is_exit ? "R8 ack drop" : "R5 ack rise",
        {cmd_valid, pm_ack}, {1'b0, level});
    reg_we = 1'b0;
    pm_req = level;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    en_m = 1'b0;
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pm_ack && !cmd_valid, "R1 reset outputs", {pm_ack, cmd_valid}, 0);
    rd(8'h10, 16'h0, "R1 enable reset");
    for (int i = 0; i < 8; i++) rd(cmd_addr(i), 16'h0, "R1 cmd reset");

    for (int i = 0; i < 8; i++) wr(cmd_addr(i), 16'(16'h0A00 + 16'h11 * i));
    wr(8'h10, 16'h0001);
    for (int i = 0; i < 8; i++) rd(cmd_addr(i), m[i], "R2 cmd readback");
    rd(8'h10, 16'h0001, "R2 enable readback");
    rd(8'h14, 16'h0, "R2 unmapped 0x14");
    rd(8'h38, 16'h0, "R2 unmapped 0x38");

    run_seq(1'b0, 1'b0);
    hold(12, 1'b1, "R7 held high");
    run_seq(1'b1, 1'b0);
    hold(12, 1'b0, "R7 held low");

    wr(8'h10, 16'h0000);
    @(negedge clk); pm_req = 1'b1;
    hold(10, 1'b0, "R6 disabled rise");
    @(negedge clk); pm_req = 1'b0;
    hold(6, 1'b0, "R6 disabled fall");

    wr(cmd_addr(3), 16'hF123);
    wr(cmd_addr(7), 16'hF456);
    wr(8'h10, 16'h0001);
    run_seq(1'b0, 1'b1);
    hold(4, 1'b1, "R7 after max wait");
    run_seq(1'b1, 1'b1);
    hold(4, 1'b0, "R7 after exit");

    for (int it = 0; it < 30; it++) begin
      for (int i = 0; i < 8; i++)
        wr(cmd_addr(i), {4'($urandom % 5), 12'($urandom)});
      wr(8'h10, 16'($urandom % 4 != 0));
      if (en_m) begin
        run_seq(1'b0, 1'b1);
        hold(3, 1'b1, "R7 random hold high");
        for (int i = 0; i < 8; i++) rd(cmd_addr(i), m[i], "R9 writes landed");
        run_seq(1'b1, 1'b1);
        hold(3, 1'b0, "R7 random hold low");
      end else begin
        @(negedge clk); pm_req = 1'b1;
        hold(5, 1'b0, "R6 random disabled");
        @(negedge clk); pm_req = 1'b0;
        hold(3, 1'b0, "R6 random disabled fall");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule